// File: doc/BRIEF.md
# Sequencer Branch and Program-Counter Unit

This block keeps the 5-bit instruction address of a small I/O sequencer core and resolves its conditional jumps. Each cycle the decoder may present a jump request with a 3-bit condition code and a 5-bit target. The unit tests the condition against two 32-bit scratch registers (X and Y), one input pin chosen by a select field, and the empty flag of the output shift register. It then loads the target or moves to the next address. For the count-down loop codes it also decrements the tested register as a side effect.

The scratch registers live inside the unit. Other instructions load them through dedicated load ports. Instructions that write the address directly use a separate write port. A stall input freezes all architectural state while the core waits on something else.

The address register is driven by a per-cycle action selector with four named actions, chosen in priority order:
- ACT_HOLD: the stall input is high.
- ACT_WRITE: a direct write is requested.
- ACT_JUMP: a jump request whose condition holds.
- ACT_STEP: every other case.

The transitions are:
- ACT_HOLD keeps the address.
- ACT_WRITE loads the write data.
- ACT_JUMP loads the target.
- ACT_STEP adds one, wrapping from 31 to 0.

Top module: `branch_pc_unit`

## Requirements
- R1: After reset the address, X and Y all read 0.
- R2: Condition code 0 always jumps: the address becomes the target on the next edge.
- R3: Code 1 jumps when X is 0, and code 3 jumps when Y is 0.
- R4: Code 2 jumps when X is non-zero, and code 4 jumps when Y is non-zero. The test uses the value before the cycle. The tested register is decremented whether or not the jump is taken, and 0 wraps to all ones.
- R5: Code 5 jumps when X differs from Y.
- R6: Code 6 jumps when the input pin chosen by the select field is 1.
- R7: Code 7 jumps when the output-shift-register empty flag is 0.
- R8: When no jump is taken and no direct write is requested, the address advances by one, wrapping from 31 to 0.
- R9: While stall is high, the address, X and Y keep their values. Jumps, loads and writes in that cycle are ignored.
- R10: A direct address write overrides both a taken jump and the increment in the same cycle.
- R11: A load of X or Y takes effect on the next edge and overrides a loop decrement of the same register in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Freeze all state this cycle |
| jmp_valid_i | input | 1 | Jump request present |
| jmp_cond_i | input | 3 | Condition code (0 to 7) |
| jmp_target_i | input | 5 | Jump target address |
| pin_i | input | 8 | Input pin bus |
| pin_sel_i | input | 3 | Index of the pin tested by code 6 |
| osr_empty_i | input | 1 | Output shift register empty flag |
| pc_wr_i | input | 1 | Direct address write request |
| pc_wr_data_i | input | 5 | Address to write |
| x_ld_i | input | 1 | Load X |
| x_ld_data_i | input | 32 | Value for X |
| y_ld_i | input | 1 | Load Y |
| y_ld_data_i | input | 32 | Value for Y |
| pc_o | output | 5 | Current address |
| x_o | output | 32 | Scratch register X |
| y_o | output | 32 | Scratch register Y |
| taken_o | output | 1 | Jump taken this cycle (combinational) |

## Verification
The taken flag is combinational and is due in the same cycle as the request. The bench reads it at the falling edge, after driving the inputs, and before the rising edge. Address, X and Y are registered and are due one rising edge after the stimulus. The bench therefore drives at a falling edge, waits one rising edge, and samples at the next falling edge. Preloads of X, Y and the address use their own cycle, so every table vector tests only the jump cycle.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    typedef enum logic [2:0] {
        BR_ALWAYS   = 3'd0,
        BR_X_ZERO   = 3'd1,
        BR_X_LOOP   = 3'd2,
        BR_Y_ZERO   = 3'd3,
        BR_Y_LOOP   = 3'd4,
        BR_X_NE_Y   = 3'd5,
        BR_PIN_HIGH = 3'd6,
        BR_OSR_DATA = 3'd7
    } br_cond_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_WRITE = 2'd1,
        ACT_JUMP  = 2'd2,
        ACT_STEP  = 2'd3
    } pc_act_e;

endpackage

// File: rtl/bpu_cond_eval.sv
module bpu_cond_eval
    import bpu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PIN_W  = 8,
    localparam int SEL_W = $clog2(PIN_W)
) (
    input  br_cond_e              cond,
    input  logic [DATA_W-1:0]     x_val,
    input  logic [DATA_W-1:0]     y_val,
    input  logic [PIN_W-1:0]      pins,
    input  logic [SEL_W-1:0]      pin_sel,
    input  logic                  osr_empty,
    output logic                  hit,
    output logic                  dec_x,
    output logic                  dec_y
);

    logic x_is_zero;
    logic y_is_zero;

    assign x_is_zero = (x_val == '0);
    assign y_is_zero = (y_val == '0);

    always_comb begin
        hit   = 1'b0;
        dec_x = 1'b0;
        dec_y = 1'b0;
        unique case (cond)
            BR_ALWAYS:   hit = 1'b1;
            BR_X_ZERO:   hit = x_is_zero;
            BR_X_LOOP: begin
                hit   = !x_is_zero;
                dec_x = 1'b1;
            end
            BR_Y_ZERO:   hit = y_is_zero;
            BR_Y_LOOP: begin
                hit   = !y_is_zero;
                dec_y = 1'b1;
            end
            BR_X_NE_Y:   hit = (x_val != y_val);
            BR_PIN_HIGH: hit = pins[pin_sel];
            BR_OSR_DATA: hit = !osr_empty;
        endcase
    end

    // R4: a loop code never decrements both registers
    always_comb begin
        assert_single_dec_R4: assert (!(dec_x && dec_y));
    end

endmodule

// File: rtl/bpu_scratch.sv
module bpu_scratch #(
    parameter int DATA_W = 32,
    localparam int NREG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              x_ld,
    input  logic [DATA_W-1:0] x_ld_data,
    input  logic              y_ld,
    input  logic [DATA_W-1:0] y_ld_data,
    input  logic              dec_x,
    input  logic              dec_y,
    output logic [DATA_W-1:0] x_val,
    output logic [DATA_W-1:0] y_val
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [NREG-1:0]             ld_v;
    logic [NREG-1:0]             dec_v;
    logic [NREG-1:0][DATA_W-1:0] ld_d;
    logic [NREG-1:0][DATA_W-1:0] regs;

    assign ld_v  = {y_ld, x_ld};
    assign dec_v = {dec_y, dec_x};
    assign ld_d  = {y_ld_data, x_ld_data};

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (!stall) begin
                if (ld_v[g]) begin
                    regs[g] <= ld_d[g];
                end else if (dec_v[g]) begin
                    regs[g] <= regs[g] - ONE;
                end
            end
        end

        // R9: stalled cycle leaves the register untouched
        assert_scratch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            stall |=> $stable(regs[g]));

        // R4: unloaded loop decrement lowers the register by one
        assert_loop_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!stall && dec_v[g] && !ld_v[g]) |=> (regs[g] == $past(regs[g]) - ONE));

        // R11: a load wins over a decrement
        assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!stall && ld_v[g]) |=> (regs[g] == $past(ld_d[g])));
    end

    assign x_val = regs[0];
    assign y_val = regs[1];

endmodule

// File: rtl/bpu_pc_seq.sv
module bpu_pc_seq
    import bpu_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              jump_en,
    input  logic [ADDR_W-1:0] jump_addr,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

    pc_act_e           act;
    logic [ADDR_W-1:0] pc_nxt;

    always_comb begin
        if (stall)        act = ACT_HOLD;
        else if (wr_en)   act = ACT_WRITE;
        else if (jump_en) act = ACT_JUMP;
        else              act = ACT_STEP;
    end

    always_comb begin
        unique case (act)
            ACT_HOLD:  pc_nxt = pc;
            ACT_WRITE: pc_nxt = wr_addr;
            ACT_JUMP:  pc_nxt = jump_addr;
            ACT_STEP:  pc_nxt = pc + PC_ONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_nxt;
    end

    assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc));

    assert_pc_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && wr_en) |=> (pc == $past(wr_addr)));

    assert_pc_jump_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !wr_en && jump_en) |=> (pc == $past(jump_addr)));

    assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !wr_en && !jump_en) |=> (pc == $past(pc) + PC_ONE));

endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
    import bpu_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int PIN_W  = 8,
    localparam int SEL_W = $clog2(PIN_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              jmp_valid_i,
    input  logic [2:0]        jmp_cond_i,
    input  logic [ADDR_W-1:0] jmp_target_i,
    input  logic [PIN_W-1:0]  pin_i,
    input  logic [SEL_W-1:0]  pin_sel_i,
    input  logic              osr_empty_i,
    input  logic              pc_wr_i,
    input  logic [ADDR_W-1:0] pc_wr_data_i,
    input  logic              x_ld_i,
    input  logic [DATA_W-1:0] x_ld_data_i,
    input  logic              y_ld_i,
    input  logic [DATA_W-1:0] y_ld_data_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] x_o,
    output logic [DATA_W-1:0] y_o,
    output logic              taken_o
);

    logic hit;
    logic dec_x_raw;
    logic dec_y_raw;
    logic dec_x;
    logic dec_y;
    logic jump_en;

    bpu_cond_eval #(.DATA_W(DATA_W), .PIN_W(PIN_W)) u_cond (
        .cond      (br_cond_e'(jmp_cond_i)),
        .x_val     (x_o),
        .y_val     (y_o),
        .pins      (pin_i),
        .pin_sel   (pin_sel_i),
        .osr_empty (osr_empty_i),
        .hit       (hit),
        .dec_x     (dec_x_raw),
        .dec_y     (dec_y_raw)
    );

    assign jump_en = jmp_valid_i && hit;
    assign dec_x   = jmp_valid_i && dec_x_raw;
    assign dec_y   = jmp_valid_i && dec_y_raw;
    assign taken_o = jump_en && !stall_i;

    bpu_scratch #(.DATA_W(DATA_W)) u_scratch (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall_i),
        .x_ld      (x_ld_i),
        .x_ld_data (x_ld_data_i),
        .y_ld      (y_ld_i),
        .y_ld_data (y_ld_data_i),
        .dec_x     (dec_x),
        .dec_y     (dec_y),
        .x_val     (x_o),
        .y_val     (y_o)
    );

    bpu_pc_seq #(.ADDR_W(ADDR_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall_i),
        .wr_en     (pc_wr_i),
        .wr_addr   (pc_wr_data_i),
        .jump_en   (jump_en),
        .jump_addr (jmp_target_i),
        .pc        (pc_o)
    );

    // R2/R3: an always-jump request is taken whenever the unit is not stalled
    assert_always_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_valid_i && jmp_cond_i == 3'd0 && !stall_i) |-> taken_o);

    // R9: nothing is taken during a stall
    assert_no_take_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> !taken_o);

endmodule

// File: tb/tb_branch_pc_unit.sv
module tb_branch_pc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0;
    logic        jmp_valid_i = 1'b0;
    logic [2:0]  jmp_cond_i = '0;
    logic [4:0]  jmp_target_i = '0;
    logic [7:0]  pin_i = '0;
    logic [2:0]  pin_sel_i = '0;
    logic        osr_empty_i = 1'b1;
    logic        pc_wr_i = 1'b0;
    logic [4:0]  pc_wr_data_i = '0;
    logic        x_ld_i = 1'b0;
    logic [31:0] x_ld_data_i = '0;
    logic        y_ld_i = 1'b0;
    logic [31:0] y_ld_data_i = '0;
    logic [4:0]  pc_o;
    logic [31:0] x_o;
    logic [31:0] y_o;
    logic        taken_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    branch_pc_unit dut (.*);

    typedef struct packed {
        logic [31:0] x;
        logic [31:0] y;
        logic [2:0]  cond;
        logic [4:0]  tgt;
        logic        pin;
        logic        osre;
        logic [4:0]  start;
        logic [4:0]  epc;
        logic [31:0] ex;
        logic [31:0] ey;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'd0, 32'd0, 3'd0, 5'd20, 1'b0, 1'b1, 5'd10, 5'd20, 32'd0, 32'd0},              // R2
        '{32'd0, 32'd6, 3'd1, 5'd20, 1'b0, 1'b1, 5'd10, 5'd20, 32'd0, 32'd6},              // R3
        '{32'd5, 32'd0, 3'd1, 5'd20, 1'b0, 1'b1, 5'd10, 5'd11, 32'd5, 32'd0},              // R3
        '{32'd3, 32'd0, 3'd2, 5'd20, 1'b0, 1'b1, 5'd10, 5'd20, 32'd2, 32'd0},              // R4
        '{32'd0, 32'd0, 3'd2, 5'd20, 1'b0, 1'b1, 5'd10, 5'd11, 32'hFFFF_FFFF, 32'd0},      // R4
        '{32'd8, 32'd0, 3'd3, 5'd20, 1'b0, 1'b1, 5'd10, 5'd20, 32'd8, 32'd0},              // R3
        '{32'd0, 32'd7, 3'd3, 5'd20, 1'b0, 1'b1, 5'd10, 5'd11, 32'd0, 32'd7},              // R3
        '{32'd0, 32'd1, 3'd4, 5'd20, 1'b0, 1'b1, 5'd10, 5'd20, 32'd0, 32'd0},              // R4
        '{32'd0, 32'd0, 3'd4, 5'd20, 1'b0, 1'b1, 5'd10, 5'd11, 32'd0, 32'hFFFF_FFFF},      // R4
        '{32'd4, 32'd4, 3'd5, 5'd20, 1'b0, 1'b1, 5'd10, 5'd11, 32'd4, 32'd4},              // R5
        '{32'd4, 32'd9, 3'd5, 5'd20, 1'b0, 1'b1, 5'd10, 5'd20, 32'd4, 32'd9},              // R5
        '{32'd0, 32'd0, 3'd6, 5'd20, 1'b1, 1'b1, 5'd10, 5'd20, 32'd0, 32'd0},              // R6
        '{32'd0, 32'd0, 3'd6, 5'd20, 1'b0, 1'b1, 5'd10, 5'd11, 32'd0, 32'd0},              // R6
        '{32'd0, 32'd0, 3'd7, 5'd20, 1'b0, 1'b0, 5'd10, 5'd20, 32'd0, 32'd0},              // R7
        '{32'd0, 32'd0, 3'd7, 5'd20, 1'b0, 1'b1, 5'd10, 5'd11, 32'd0, 32'd0},              // R7
        '{32'd0, 32'd0, 3'd0, 5'd3,  1'b0, 1'b1, 5'd31, 5'd3,  32'd0, 32'd0},              // R2
        '{32'd1, 32'd0, 3'd1, 5'd3,  1'b0, 1'b1, 5'd31, 5'd0,  32'd1, 32'd0}               // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        stall_i = 1'b0; jmp_valid_i = 1'b0; pc_wr_i = 1'b0;
        x_ld_i = 1'b0; y_ld_i = 1'b0; osr_empty_i = 1'b1; pin_i = '0;
    endtask

    task automatic preload(input logic [31:0] xv, input logic [31:0] yv, input logic [4:0] p);
        idle_inputs();
        x_ld_i = 1'b1; x_ld_data_i = xv;
        y_ld_i = 1'b1; y_ld_data_i = yv;
        pc_wr_i = 1'b1; pc_wr_data_i = p;
        tick();
        idle_inputs();
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pc", {27'd0, pc_o}, 32'd0);
        check("R1 x", x_o, 32'd0);
        check("R1 y", y_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            preload(VECS[i].x, VECS[i].y, VECS[i].start);
            jmp_valid_i  = 1'b1;
            jmp_cond_i   = VECS[i].cond;
            jmp_target_i = VECS[i].tgt;
            pin_sel_i    = 3'(i % 8);
            pin_i        = VECS[i].pin ? (8'd1 << (i % 8)) : ~(8'd1 << (i % 8));
            osr_empty_i  = VECS[i].osre;
            #1;
            check($sformatf("R2-vector%0d taken", i), {31'd0, taken_o},
                  {31'd0, VECS[i].epc == VECS[i].tgt && VECS[i].start != 5'd31 ? 1'b1 :
                          (VECS[i].epc == VECS[i].tgt)});
            tick();
            check($sformatf("vector%0d pc (R2 R3 R4 R5 R6 R7 R8)", i), {27'd0, pc_o}, {27'd0, VECS[i].epc});
            check($sformatf("vector%0d x (R4)", i), x_o, VECS[i].ex);
            check($sformatf("vector%0d y (R4)", i), y_o, VECS[i].ey);
            idle_inputs();
        end

        // R8: no request, plain step
        preload(32'd0, 32'd0, 5'd7);
        tick();
        check("R8 step", {27'd0, pc_o}, 32'd8);

        // R9: stall freezes everything, even with requests present
        preload(32'd3, 32'd5, 5'd12);
        stall_i = 1'b1;
        jmp_valid_i = 1'b1; jmp_cond_i = 3'd2; jmp_target_i = 5'd1;
        pc_wr_i = 1'b1; pc_wr_data_i = 5'd9;
        y_ld_i = 1'b1; y_ld_data_i = 32'd77;
        #1;
        check("R9 taken low", {31'd0, taken_o}, 32'd0);
        tick();
        tick();
        check("R9 pc", {27'd0, pc_o}, 32'd12);
        check("R9 x", x_o, 32'd3);
        check("R9 y", y_o, 32'd5);
        idle_inputs();

        // R10: write beats a taken jump
        preload(32'd0, 32'd0, 5'd4);
        jmp_valid_i = 1'b1; jmp_cond_i = 3'd0; jmp_target_i = 5'd25;
        pc_wr_i = 1'b1; pc_wr_data_i = 5'd17;
        tick();
        check("R10 pc", {27'd0, pc_o}, 32'd17);
        idle_inputs();

        // R11: load beats loop decrement; jump decision uses old X
        preload(32'd3, 32'd0, 5'd2);
        jmp_valid_i = 1'b1; jmp_cond_i = 3'd2; jmp_target_i = 5'd30;
        x_ld_i = 1'b1; x_ld_data_i = 32'd9;
        tick();
        check("R11 x", x_o, 32'd9);
        check("R11 pc", {27'd0, pc_o}, 32'd30);
        idle_inputs();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule